// File: doc/BRIEF.md
# Configurable Read Output Pipeline

This block is the read data return path of a synchronous SRAM. Each clock it receives one already-registered command (idle, read, deselect or write) together with the array data fetched for that cycle. It produces the data word for the output pads and a pad output-enable. A mode input selects where that word comes from. In flow-through mode the array data goes straight to the pads. In pipelined mode the data passes through a rising-edge output register, which adds one cycle.

A second mode input selects when a deselect turns the outputs off. With dual-cycle deselect, a deselect goes through the same stages as read data. With single-cycle deselect, it goes through one stage fewer. A write always turns the outputs off at once, so the bus is never driven while write data arrives. Two asynchronous inputs override everything: output-enable and sleep. Sleep also freezes the block's internal state. Both mode inputs may change while the block runs.

Top module: `read_out_pipe`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pad_oe` is 0 and `pad_data` is all zeros (with `cmd` idle).
- R2: Command encoding on `cmd`: 0 idle, 1 read, 2 deselect, 3 write. In flow-through mode (`mode_pipe`=0), a read cycle shows `arr_rdata` on `pad_data` in that same cycle, with the synchronous enable active.
- R3: In pipelined mode (`mode_pipe`=1), the data of a read appears on `pad_data` in the following cycle, with the synchronous enable active. It is held until the next accepted read.
- R4: In pipelined mode with dual-cycle deselect (`mode_dual`=1), the outputs stay enabled during the deselect cycle and are off from the next cycle on.
- R5: In pipelined mode with single-cycle deselect (`mode_dual`=0), the outputs are off already in the deselect cycle.
- R6: In flow-through mode, a deselect turns the outputs off in its own cycle for either deselect setting.
- R7: A write cycle has `pad_oe`=0 in every mode, and the outputs stay off afterwards until a read.
- R8: An idle cycle keeps the drive state and the held data word. In flow-through mode the held word is the data of the last read.
- R9: `oe_in`=0 forces `pad_oe` to 0 in the same cycle without clocking, and does not change the internal state.
- R10: `sleep_in`=1 forces `pad_oe` to 0 at once and freezes all internal state. Commands given during sleep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_pipe | input | 1 | 1 = pipelined output register, 0 = flow-through |
| mode_dual | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect |
| cmd | input | 2 | Registered command: 0 idle, 1 read, 2 deselect, 3 write |
| arr_rdata | input | DW | Array read data for the current cycle |
| oe_in | input | 1 | Asynchronous output enable, active high |
| sleep_in | input | 1 | Asynchronous sleep, active high |
| pad_data | output | DW | Data toward the output pads |
| pad_oe | output | 1 | Tri-state enable toward the pads |

## Verification
On every cycle, the assertions check the following:
- a write never has the outputs enabled;
- single-cycle deselect in pipelined mode is off in its own cycle;
- a dual-cycle deselect leaves the outputs off in the next cycle;
- a read shows its data in the right cycle for each output mode;
- the pipelined data word stays still during sleep.

Some behaviour only the bench's scenarios can show. These are the reset state, and that a command given during sleep or with output-enable low leaves no trace after wake-up. They also include what an idle cycle holds, and run-time changes of the modes inside a burst. The bench covers these with a reference model over directed and random command streams.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_WRITE = 2'd3
  } rop_cmd_e;
endpackage

// File: rtl/rop_cmd_decode.sv
module rop_cmd_decode
  import rop_pkg::*;
(
  input  logic [1:0] cmd,
  output logic       is_read,
  output logic       is_desel,
  output logic       is_write
);
  rop_cmd_e cmd_e;

  always_comb begin
    cmd_e    = rop_cmd_e'(cmd);
    is_read  = (cmd_e == CMD_READ);
    is_desel = (cmd_e == CMD_DESEL);
    is_write = (cmd_e == CMD_WRITE);
  end
endmodule

// File: rtl/rop_data_stage.sv
module rop_data_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (cap_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/rop_enable_ctrl.sv
module rop_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic is_read,
  input  logic is_desel,
  input  logic is_write,
  input  logic mode_pipe,
  input  logic mode_dual,
  output logic sync_en
);
  logic drv_q;
  logic drv_nxt;
  logic kill_now;

  always_comb begin
    drv_nxt = drv_q;
    if (step_en) begin
      if (is_read)                    drv_nxt = 1'b1;
      else if (is_desel || is_write)  drv_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_nxt;
  end

  always_comb begin
    if (mode_pipe) begin
      kill_now = is_write || (is_desel && !mode_dual);
      sync_en  = drv_q && !kill_now;
    end else begin
      kill_now = is_write || is_desel;
      sync_en  = is_read || (drv_q && !kill_now);
    end
  end
endmodule

// File: rtl/read_out_pipe.sv
module read_out_pipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pipe,
  input  logic          mode_dual,
  input  logic [1:0]    cmd,
  input  logic [DW-1:0] arr_rdata,
  input  logic          oe_in,
  input  logic          sleep_in,
  output logic [DW-1:0] pad_data,
  output logic          pad_oe
);
  logic          is_read;
  logic          is_desel;
  logic          is_write;
  logic          step_en;
  logic          sync_en;
  logic [DW-1:0] data_q;

  assign step_en = !sleep_in;

  rop_cmd_decode u_dec (
    .cmd      (cmd),
    .is_read  (is_read),
    .is_desel (is_desel),
    .is_write (is_write)
  );

  rop_data_stage #(.DW(DW)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (is_read && step_en),
    .d      (arr_rdata),
    .q      (data_q)
  );

  rop_enable_ctrl u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .is_read   (is_read),
    .is_desel  (is_desel),
    .is_write  (is_write),
    .mode_pipe (mode_pipe),
    .mode_dual (mode_dual),
    .sync_en   (sync_en)
  );

  always_comb begin
    if (!mode_pipe && is_read) pad_data = arr_rdata;
    else                       pad_data = data_q;
    pad_oe = sync_en && oe_in && !sleep_in;
  end
endmodule

// File: rtl/read_out_pipe_chk.sv
module read_out_pipe_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_pipe,
  input logic          mode_dual,
  input logic [1:0]    cmd,
  input logic [DW-1:0] arr_rdata,
  input logic          oe_in,
  input logic          sleep_in,
  input logic [DW-1:0] pad_data,
  input logic          pad_oe
);
  assert_write_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |-> !pad_oe);

  assert_scd_early_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && !mode_dual && cmd == 2'd2) |-> !pad_oe);

  assert_dcd_next_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && cmd == 2'd2 && !sleep_in) |=> (!mode_pipe || !pad_oe));

  assert_ft_same_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && cmd == 2'd1) |-> (pad_data == arr_rdata));

  assert_pipe_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && cmd == 2'd1 && !sleep_in) |=>
      (!mode_pipe || pad_data == $past(arr_rdata)));

  assert_async_gate_R9_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_in || sleep_in) |-> !pad_oe);

  assert_sleep_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_in && mode_pipe) |=> (!mode_pipe || pad_data == $past(pad_data)));
endmodule

bind read_out_pipe read_out_pipe_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_pipe (mode_pipe),
  .mode_dual (mode_dual),
  .cmd       (cmd),
  .arr_rdata (arr_rdata),
  .oe_in     (oe_in),
  .sleep_in  (sleep_in),
  .pad_data  (pad_data),
  .pad_oe    (pad_oe)
);

// File: tb/read_out_pipe_bench.sv
module read_out_pipe_bench;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;

  logic          clk;
  logic          rst_n;
  logic          mode_pipe;
  logic          mode_dual;
  logic [1:0]    cmd;
  logic [DW-1:0] arr_rdata;
  logic          oe_in;
  logic          sleep_in;
  logic [DW-1:0] pad_data;
  logic          pad_oe;

  int n_checks;
  int n_fail;
  bit done;

  logic          m_drv;
  logic [DW-1:0] m_data;

  read_out_pipe #(.DW(DW)) u_read_out_pipe (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .mode_dual(mode_dual),
    .cmd(cmd), .arr_rdata(arr_rdata), .oe_in(oe_in), .sleep_in(sleep_in),
    .pad_data(pad_data), .pad_oe(pad_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_sync(logic drv, logic [1:0] c, logic p, logic d);
    if (p) return drv && c != 2'd3 && !(c == 2'd2 && !d);
    return (c == 2'd1) || (drv && c != 2'd2 && c != 2'd3);
  endfunction

  function automatic logic [DW-1:0] exp_data(logic [DW-1:0] held, logic [1:0] c,
                                             logic p, logic [DW-1:0] a);
    if (!p && c == 2'd1) return a;
    return held;
  endfunction

  task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // One cycle: drive at negedge, compare against model, then advance model at posedge.
  task automatic step(string tag, logic [1:0] c, logic [DW-1:0] a,
                      logic oe = 1'b1, logic slp = 1'b0);
    logic e_oe;
    @(negedge clk);
    cmd = c; arr_rdata = a; oe_in = oe; sleep_in = slp;
    #1;
    e_oe = exp_sync(m_drv, c, mode_pipe, mode_dual) && oe && !slp;
    check(tag, {pad_oe, pad_data}, {e_oe, exp_data(m_data, c, mode_pipe, a)});
    if (!slp) begin
      if (c == 2'd1) begin m_drv = 1'b1; m_data = a; end
      else if (c == 2'd2 || c == 2'd3) m_drv = 1'b0;
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_pipe = 1'b1; mode_dual = 1'b0;
    cmd = 2'd0; arr_rdata = '0; oe_in = 1'b1; sleep_in = 1'b0;
    m_drv = 1'b0; m_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {pad_oe, pad_data}, '0);
    rst_n = 1'b1;
    step("R1 after reset", 2'd0, 16'h1111);

    // R3 pipelined read, R5 single-cycle deselect
    step("R3 read issue", 2'd1, 16'hA001);
    step("R3 data next cycle", 2'd1, 16'hA002);
    step("R8 idle holds", 2'd0, 16'hFFFF);
    step("R5 scd off now", 2'd2, 16'h0000);
    check("R5 literal", {pad_oe, 16'h0}, '0);
    step("R5 stays off", 2'd0, 16'h0000);

    // R4 dual-cycle deselect
    mode_dual = 1'b1;
    step("R4 read", 2'd1, 16'hB00B);
    step("R4 desel still on", 2'd2, 16'h0);
    check("R4 literal on", {pad_oe, pad_data}, {1'b1, 16'hB00B});
    step("R4 off next", 2'd0, 16'h0);
    check("R4 literal off", {16'h0, pad_oe}, '0);

    // R2 / R6 flow-through
    mode_pipe = 1'b0;
    step("R2 ft read", 2'd1, 16'hC0C0);
    step("R8 ft idle holds", 2'd0, 16'h1234);
    step("R6 ft desel dcd", 2'd2, 16'h0);
    mode_dual = 1'b0;
    step("R2 ft read2", 2'd1, 16'hC1C1);
    step("R6 ft desel scd", 2'd2, 16'h0);

    // R7 writes in both modes
    step("R2 ft read3", 2'd1, 16'hD0D0);
    step("R7 ft write", 2'd3, 16'h0);
    step("R7 after write", 2'd0, 16'h0);
    mode_pipe = 1'b1; mode_dual = 1'b1;
    step("R3 pipe read", 2'd1, 16'hD1D1);
    step("R7 pipe write dcd", 2'd3, 16'h0);
    step("R7 after write dcd", 2'd0, 16'h0);

    // R9 async output enable, R10 sleep
    step("R3 read", 2'd1, 16'hE0E0);
    step("R9 oe low", 2'd0, 16'h0, 1'b0);
    step("R9 oe back", 2'd0, 16'h0);
    step("R10 sleep ignores read", 2'd1, 16'h5A5A, 1'b1, 1'b1);
    step("R10 sleep ignores desel", 2'd2, 16'h0, 1'b1, 1'b1);
    step("R10 wake state kept", 2'd0, 16'h0);
    check("R10 literal", {pad_oe, pad_data}, {1'b1, 16'hE0E0});

    // random mix
    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 0) begin
        mode_pipe = 1'($urandom_range(0, 1));
        mode_dual = 1'($urandom_range(0, 1));
      end
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random",
           2'($urandom_range(0, 3)), 16'($urandom),
           ($urandom_range(0, 9) != 0), ($urandom_range(0, 19) == 0));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule